// File: doc/BRIEF.md
# Shared External Bus Owner Arbiter

This block sits on the side that owns a shared external bus by default, with one other device able to borrow it. The other device pulls an active-low request line. The arbiter samples that line on the falling edge of the bus clock. It stops driving the bus control strobes and the address/data buses on the following rising edge, and half a cycle later it asserts an active-low grant. When the borrower lets go of the request, the arbiter takes the bus back on a fixed timeline that uses both clock edges. The strobes are driven again (at their inactive level) 1.5 cycles after the withdrawal is seen. The grant is negated on the next falling edge. Address and data drive resumes on the rising edge after that, which is also the first edge on which a real access may begin.

A refresh timer outside the block pulses a pending input when an SDRAM refresh is due. While the bus is lent out, a pending refresh holds an active-low refresh-ask output low to urge the borrower to hand the bus back. The ask stays low until ownership returns. On return, the arbiter issues a one-cycle refresh-go strobe before it does anything else. When a refresh and a request arrive together while the arbiter owns the bus, the refresh goes first. After a hand-back, the arbiter keeps the bus for a minimum number of owned cycles before it lends it out again.

Top module: `bus_owner_arb`

## Requirements
- R1: During and after synchronous reset (rst_n low), the block owns the bus: strb_oe=1, addr_oe=1, gnt_n=1, rfsh_ask_n=1, rfsh_go=0.
- R2: req_n is active low and is sampled only on falling clock edges. A low level seen on a falling edge, while the bus is owned, free of hold and with no refresh pending, clears strb_oe and addr_oe on the next rising edge. A low pulse that does not cover a falling edge has no effect.
- R3: gnt_n goes low on the falling edge that follows the release of strb_oe and addr_oe. gnt_n is never low while addr_oe is 1.
- R4: When req_n is seen high on a falling edge while the bus is granted, strb_oe returns to 1 exactly 1.5 cycles later (the second rising edge), and stays 0 on the first rising edge.
- R5: gnt_n returns to 1 on the falling edge that follows the return of strb_oe.
- R6: addr_oe returns to 1 on the rising edge that follows the negation of gnt_n. This is the first edge on which an access may start.
- R7: rfsh_ask_n is low exactly while a refresh is pending and gnt_n is low. Once asserted, it stays low until gnt_n returns to 1.
- R8: rfsh_go is a one-cycle pulse with addr_oe=1. A refresh pending at hand-back pulses it on the rising edge where addr_oe returns. A refresh pending while the bus is owned pulses it on the next rising edge, and that edge lends nothing out, even if a request is waiting.
- R9: After addr_oe returns, it stays 1 for at least MIN_OWN rising edges (default 2) before the next release, even if req_n is held low throughout recovery. Requests seen during recovery do not alter the recovery timeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges used |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 1 | Bus request from the borrowing device, active low |
| rfsh_pend | input | 1 | Refresh-due pulse from the refresh timer, sampled on rising edges |
| gnt_n | output | 1 | Bus grant to the borrowing device, active low |
| rfsh_ask_n | output | 1 | Asks the borrower to give the bus back for refresh, active low |
| strb_oe | output | 1 | Drive enable for the bus control strobes |
| addr_oe | output | 1 | Drive enable for the address and data buses |
| rfsh_go | output | 1 | One-cycle strobe: perform the pending refresh now |

## Verification
Each result is due a fixed number of half-cycles after the stimulus edge. Counting from the rising edge nearest a new request, the release is due 2 half-cycles later and the grant 3. Counting from the rising edge nearest a withdrawal, the strobes return 4 half-cycles later, the grant is negated at 5, and address drive and any refresh-go arrive at 6. The bench drives inputs 2 ns after a rising edge and samples every output 5 ns after each edge. The driver tags every expected value with the absolute half-cycle index in which it is due. The monitor compares it only in that sample, so an event that comes early, comes late or goes missing is each reported.

// File: rtl/arb_pkg.sv
// Shared types for the bus owner arbiter.
package arb_pkg;
    // Ownership sequence states advanced on the rising edge.
    typedef enum logic [2:0] {
        ST_OWN  = 3'd0,  // bus owned and driven
        ST_REL  = 3'd1,  // outputs released, grant not yet given
        ST_AWAY = 3'd2,  // bus granted to the other device
        ST_RET1 = 3'd3,  // withdrawal seen, first half of recovery
        ST_RET2 = 3'd4   // strobes driven high, grant still out
    } arb_state_e;
endpackage

// File: rtl/arb_req_sample.sv
// Samples the active-low request on the falling clock edge.
// Assumes req_n is stable around the falling edge (synchronous to clk).
module arb_req_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic req_seen
);
    // Falling-edge capture of the request, stored active high.
    always_ff @(negedge clk) begin
        if (!rst_n) req_seen <= 1'b0;
        else        req_seen <= ~req_n;
    end
endmodule

// File: rtl/arb_seq.sv
// Rising-edge sequencer: release, recovery, refresh priority and the hold
// that follows a hand-back. Assumes req_seen comes from a falling-edge register.
module arb_seq
    import arb_pkg::*;
#(
    parameter int MIN_OWN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_seen,
    input  logic       rfsh_pend,
    output arb_state_e state,
    output logic       strb_oe,
    output logic       addr_oe,
    output logic       rfsh_go,
    output logic       pend_q
);
    localparam int HW = $clog2(MIN_OWN + 1);

    arb_state_e    nxt;
    logic          take;
    logic          pend_any;
    logic [HW-1:0] hold_cnt;

    assign pend_any = pend_q | rfsh_pend;

    // Next-state choice; refresh beats lending, hold blocks lending.
    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            ST_OWN: begin
                if (pend_any)                       take = 1'b1;
                else if (hold_cnt == '0 && req_seen) nxt = ST_REL;
            end
            ST_REL:  nxt = ST_AWAY;
            ST_AWAY: if (!req_seen) nxt = ST_RET1;
            ST_RET1: nxt = ST_RET2;
            ST_RET2: begin
                nxt  = ST_OWN;
                take = pend_any;
            end
            default: nxt = ST_OWN;
        endcase
    end

    // State, registered drive enables and refresh bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OWN;
            strb_oe  <= 1'b1;
            addr_oe  <= 1'b1;
            rfsh_go  <= 1'b0;
            pend_q   <= 1'b0;
            hold_cnt <= '0;
        end else begin
            state   <= nxt;
            strb_oe <= (nxt == ST_OWN) || (nxt == ST_RET2);
            addr_oe <= (nxt == ST_OWN);
            rfsh_go <= take;
            pend_q  <= pend_any & ~take;
            if (state == ST_RET2)
                hold_cnt <= HW'(MIN_OWN - 1);
            else if (state == ST_OWN && hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // R8: the refresh strobe only fires while addresses are driven.
    p_go_on_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_go |-> addr_oe);

    // R4: strobes come back two rising edges after withdrawal was captured.
    p_strb_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_oe) |-> !$past(req_seen, 2));
endmodule

// File: rtl/arb_grant.sv
// Falling-edge grant driver: asserts after release, negates after strobes return.
// Assumes state is updated on the rising edge by the sequencer.
module arb_grant
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  arb_state_e state,
    output logic       gnt_n
);
    // Half-cycle-offset grant update.
    always_ff @(negedge clk) begin
        if (!rst_n)                gnt_n <= 1'b1;
        else if (state == ST_REL)  gnt_n <= 1'b0;
        else if (state == ST_RET2) gnt_n <= 1'b1;
    end

    // R5: grant is only negated once strobes are back (RET2 reached).
    p_gnt_neg_r5: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(gnt_n) |-> $past(state) == ST_RET2);
endmodule

// File: rtl/bus_owner_arb.sv
// Owner-side arbiter for a two-device shared external bus.
// Lends the bus on an active-low request, reclaims it on a fixed two-edge
// timeline and pushes the borrower off when a refresh is due.
// Assumes req_n and rfsh_pend are synchronous to clk.
module bus_owner_arb #(
    parameter int MIN_OWN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic rfsh_pend,
    output logic gnt_n,
    output logic rfsh_ask_n,
    output logic strb_oe,
    output logic addr_oe,
    output logic rfsh_go
);
    import arb_pkg::*;

    localparam int RW = $clog2(MIN_OWN + 1);

    logic       req_seen;
    logic       pend_q;
    arb_state_e state;

    arb_req_sample u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n    (req_n),
        .req_seen (req_seen)
    );

    arb_seq #(.MIN_OWN(MIN_OWN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_seen  (req_seen),
        .rfsh_pend (rfsh_pend),
        .state     (state),
        .strb_oe   (strb_oe),
        .addr_oe   (addr_oe),
        .rfsh_go   (rfsh_go),
        .pend_q    (pend_q)
    );

    arb_grant u_gnt (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .gnt_n (gnt_n)
    );

    // Ask for the bus back while a refresh waits and the bus is lent out.
    assign rfsh_ask_n = ~(pend_q & ~gnt_n);

    // R3: never granted while addresses are still driven.
    p_gnt_addr_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_n |-> !addr_oe);

    // R3: grant appears only after strobes were released.
    p_gnt_strb_off_r3: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(gnt_n) |-> !strb_oe);

    // R6: addresses return after strobes and after the grant is negated.
    p_addr_after_strb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> ($past(strb_oe) && gnt_n));

    // R7: the ask is only withdrawn together with the grant.
    p_ask_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_ask_n) |-> gnt_n);

    // Checker counter: rising edges seen with addresses driven (saturating).
    logic [RW-1:0] up_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                            up_run <= RW'(MIN_OWN);
        else if (!addr_oe)                     up_run <= '0;
        else if (up_run < RW'(MIN_OWN))        up_run <= up_run + 1'b1;
    end

    // R9: a release follows at least MIN_OWN owned rising edges.
    p_min_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe) |-> (up_run >= RW'(MIN_OWN)));
endmodule

// File: tb/bus_owner_arb_tb.sv
// Scoreboard bench: drivers push (half-cycle index, signal, value) items,
// a monitor samples 5 ns after every edge and checks due items.
module bus_owner_arb_tb;
    localparam int S_GNT = 0, S_ASK = 1, S_STRB = 2, S_ADDR = 3, S_GO = 4;

    typedef struct {
        int    idx;
        int    sig;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic rfsh_pend = 1'b0;
    logic gnt_n, rfsh_ask_n, strb_oe, addr_oe, rfsh_go;

    exp_t exq[$];
    int   sidx = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bus_owner_arb u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (req_n),
        .rfsh_pend  (rfsh_pend),
        .gnt_n      (gnt_n),
        .rfsh_ask_n (rfsh_ask_n),
        .strb_oe    (strb_oe),
        .addr_oe    (addr_oe),
        .rfsh_go    (rfsh_go)
    );

    function automatic logic pick(int sig);
        case (sig)
            S_GNT:   return gnt_n;
            S_ASK:   return rfsh_ask_n;
            S_STRB:  return strb_oe;
            S_ADDR:  return addr_oe;
            default: return rfsh_go;
        endcase
    endfunction

    function automatic string sname(int sig);
        case (sig)
            S_GNT:   return "gnt_n";
            S_ASK:   return "rfsh_ask_n";
            S_STRB:  return "strb_oe";
            S_ADDR:  return "addr_oe";
            default: return "rfsh_go";
        endcase
    endfunction

    task automatic push(int idx, int sig, logic val, string tag);
        exp_t e;
        e.idx = idx; e.sig = sig; e.val = val; e.tag = tag;
        exq.push_back(e);
    endtask

    // Compare every item due in the current sample, then advance the index.
    task automatic sample_now();
        while (exq.size() > 0 && exq[0].idx <= sidx) begin
            exp_t e;
            logic a;
            e = exq.pop_front();
            a = pick(e.sig);
            n_run++;
            if (e.idx < sidx || a !== e.val) begin
                n_fail++;
                $display("FAIL %s: %s at half-cycle %0d actual=%b expected=%b",
                         e.tag, sname(e.sig), e.idx, a, e.val);
            end
        end
        sidx++;
    endtask

    // Monitor: one sample 5 ns after each rising and each falling edge.
    initial begin
        forever begin
            @(posedge clk); #5; sample_now();
            @(negedge clk); #5; sample_now();
        end
    end

    // Driver sync point: 2 ns after a rising edge; next sample is index sidx.
    task automatic at_rise(output int base);
        @(posedge clk); #2;
        base = sidx;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        int b;
        // R1: reset state
        idle(5);
        at_rise(b);
        push(b, S_GNT, 1'b1, "R1"); push(b, S_ASK, 1'b1, "R1");
        push(b, S_STRB, 1'b1, "R1"); push(b, S_ADDR, 1'b1, "R1");
        push(b, S_GO, 1'b0, "R1");
        rst_n = 1'b1;
        push(b + 2, S_ADDR, 1'b1, "R1");
        idle(3);

        // R2/R3: lend the bus
        at_rise(b);
        req_n = 1'b0;
        push(b, S_STRB, 1'b1, "R2");
        push(b + 2, S_STRB, 1'b0, "R2"); push(b + 2, S_ADDR, 1'b0, "R2");
        push(b + 2, S_GNT, 1'b1, "R3");
        push(b + 3, S_GNT, 1'b0, "R3");
        idle(3);

        // R7: refresh due while lent out
        at_rise(b);
        rfsh_pend = 1'b1;
        push(b, S_ASK, 1'b1, "R7");
        push(b + 2, S_ASK, 1'b0, "R7");
        push(b + 6, S_ASK, 1'b0, "R7"); push(b + 6, S_ADDR, 1'b0, "R7");
        at_rise(b);
        rfsh_pend = 1'b0;
        idle(3);

        // R4..R8: withdrawal with refresh pending
        at_rise(b);
        req_n = 1'b1;
        push(b + 2, S_STRB, 1'b0, "R4"); push(b + 2, S_ASK, 1'b0, "R7");
        push(b + 4, S_STRB, 1'b1, "R4"); push(b + 4, S_ADDR, 1'b0, "R4");
        push(b + 4, S_GNT, 1'b0, "R5"); push(b + 4, S_ASK, 1'b0, "R7");
        push(b + 5, S_GNT, 1'b1, "R5"); push(b + 5, S_ASK, 1'b1, "R7");
        push(b + 6, S_ADDR, 1'b1, "R6"); push(b + 6, S_GO, 1'b1, "R8");
        push(b + 8, S_GO, 1'b0, "R8");
        idle(6);

        // R2/R9: lend, then withdraw and re-request during recovery
        at_rise(b);
        req_n = 1'b0;
        push(b + 2, S_ADDR, 1'b0, "R2"); push(b + 3, S_GNT, 1'b0, "R3");
        idle(3);
        at_rise(b);
        req_n = 1'b1;
        push(b + 2, S_STRB, 1'b0, "R4");
        push(b + 4, S_STRB, 1'b1, "R4"); push(b + 5, S_GNT, 1'b1, "R5");
        push(b + 6, S_ADDR, 1'b1, "R6"); push(b + 6, S_GO, 1'b0, "R8");
        push(b + 8, S_ADDR, 1'b1, "R9");
        push(b + 10, S_ADDR, 1'b0, "R9"); push(b + 11, S_GNT, 1'b0, "R9");
        at_rise(b);
        req_n = 1'b0;
        idle(8);
        at_rise(b);
        req_n = 1'b1;
        push(b + 6, S_ADDR, 1'b1, "R6");
        idle(6);

        // R8: refresh and request together while owned; refresh first
        at_rise(b);
        req_n = 1'b0; rfsh_pend = 1'b1;
        push(b + 2, S_GO, 1'b1, "R8"); push(b + 2, S_ADDR, 1'b1, "R8");
        push(b + 4, S_GO, 1'b0, "R8"); push(b + 4, S_ADDR, 1'b0, "R8");
        push(b + 5, S_GNT, 1'b0, "R3"); push(b + 5, S_ASK, 1'b1, "R7");
        at_rise(b);
        rfsh_pend = 1'b0;
        idle(3);
        at_rise(b);
        req_n = 1'b1;
        push(b + 6, S_ADDR, 1'b1, "R6"); push(b + 6, S_GO, 1'b0, "R8");
        idle(6);

        // R2: low pulse between falling edges is not seen
        at_rise(b);
        req_n = 1'b0;
        #6 req_n = 1'b1;
        push(b + 2, S_ADDR, 1'b1, "R2"); push(b + 4, S_ADDR, 1'b1, "R2");
        push(b + 5, S_GNT, 1'b1, "R2");
        idle(5);

        if (exq.size() != 0) begin
            n_fail++;
            $display("FAIL R1: %0d expected items left actual=%0d expected=0",
                     exq.size(), exq.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1: watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule